// File: doc/BRIEF.md
# Descriptor Pointer and Fetch Unit

This block is the descriptor front end of a scatter-gather DMA channel. It holds one current-descriptor pointer for the source side and one for the destination side. Each pointer keeps 49 address bits, a 32-bit low word plus a 17-bit high field, and reads back as 64 bits with the top 15 bits at zero. On command the unit loads both pointers from their start-address pairs. It reads a 16-byte descriptor as four 32-bit words over a simple request/response memory port. It splits the descriptor into address, byte count and flag fields, and it moves a pointer on to the next descriptor.

A descriptor is four 32-bit words. Word 0 is the low address, word 1 bits [16:0] are the high address, and word 2 bits [29:0] are the byte count. Word 3 carries the command in [4:3], the interrupt flag in [2], the link type in [1] and the coherency flag in [0]. Destination descriptors have no command field. A pointer advances in one of two ways. Link type 0 steps it by 16 bytes. Link type 1 reads a 64-bit next pointer stored in the 8 bytes right after the descriptor. A fetch from a pointer that is not 16-byte aligned is rejected. When the register-pointer mode is selected, descriptors come from programmed descriptor vectors and no memory read is made. The data mover uses a refill command to advance the destination side and fetch the next descriptor once its current destination buffer is used up.

Commands arrive on `cmd_valid` with a 2-bit opcode: 0 = start, 1 = fetch, 2 = advance, 3 = destination refill. `cmd_side` selects the side: 0 = source, 1 = destination.

Top module: `dfu_fetch_unit`

## Requirements
- R1: After reset both pointers read 0, `busy`, `dsc_valid`, `err_src`, `err_dst`, `err_flag` and `rd_req_valid` are 0, and the stored link type of both sides is 0.
- R2: A start command (op 0) loads the source pointer from {`src_start_hi`,`src_start_lo`} and the destination pointer from {`dst_start_hi`,`dst_start_lo`}. It clears both stored link types and `err_flag`. Pointer bits [63:49] always read 0.
- R3: In memory mode (`mem_mode`=1), a fetch (op 1) from an aligned pointer issues four reads, at the pointer and at +4, +8 and +12, each held until `rd_req_ready` and followed by one response. `dsc_valid` pulses for one cycle only after the fourth response, in the same cycle that `busy` falls. The outputs then carry address {w1[16:0],w0}, size w2[29:0], command w3[4:3], interrupt w3[2], link type w3[1] and coherency w3[0]. The link type is kept for that side.
- R4: A descriptor delivered for the destination side always shows `dsc_cmd` = 0, whatever word 3 bits [4:3] hold.
- R5: An advance (op 2) on a side whose stored link type is 0 adds 16 to that pointer and makes no memory read.
- R6: An advance on a side whose stored link type is 1 reads two words, at pointer+16 and pointer+20. The new pointer becomes {second[16:0], first}, with bits [63:49] at 0.
- R7: In memory mode, a fetch from a pointer whose bits [3:0] are not 0 makes no read. In the next cycle it delivers `dsc_valid` with every field 0 and pulses `err_src` (side 0) or `err_dst` (side 1). It sets `err_flag`, which holds until the next start, and the side's stored link type becomes 0.
- R8: In register mode (`mem_mode`=0), a fetch takes the descriptor from `src_prog` or `dst_prog`, with word n at bits [32n+31:32n]. It makes no read and raises `dsc_valid` in the cycle after the command.
- R9: A refill (op 3) in memory mode advances the destination pointer as in R5/R6 and then fetches the destination descriptor as in R3/R7. In register mode a refill is ignored: no read, no pointer change, no `dsc_valid`.
- R10: Any command presented while `busy` is 1 is ignored.
- R11: While `rd_req_valid` is 1 and `rd_req_ready` is 0, the request stays valid with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_mode | input | 1 | 1 = descriptors in memory, 0 = programmed descriptor vectors |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 0 start, 1 fetch, 2 advance, 3 destination refill |
| cmd_side | input | 1 | 0 source, 1 destination |
| src_start_lo | input | 32 | Source start address, low word |
| src_start_hi | input | 17 | Source start address, high field |
| dst_start_lo | input | 32 | Destination start address, low word |
| dst_start_hi | input | 17 | Destination start address, high field |
| src_prog | input | 128 | Programmed source descriptor, word n at [32n+31:32n] |
| dst_prog | input | 128 | Programmed destination descriptor |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 49 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| busy | output | 1 | A multi-cycle command is in progress |
| cur_src_ptr | output | 64 | Current source descriptor pointer |
| cur_dst_ptr | output | 64 | Current destination descriptor pointer |
| dsc_valid | output | 1 | One-cycle pulse: descriptor fields valid |
| dsc_side | output | 1 | Side of the delivered descriptor |
| dsc_addr | output | 49 | Buffer address |
| dsc_size | output | 30 | Byte count |
| dsc_cmd | output | 2 | Command field (0 for destination) |
| dsc_intr | output | 1 | Interrupt-on-completion flag |
| dsc_linked | output | 1 | Link type: 1 = next pointer stored after the descriptor |
| dsc_coherent | output | 1 | Coherency flag |
| err_src | output | 1 | Pulse: misaligned source fetch |
| err_dst | output | 1 | Pulse: misaligned destination fetch |
| err_flag | output | 1 | Sticky error, cleared by start |

## Verification
Fetches are run against descriptors that use different word-3 encodings, so a field taken from the wrong bit positions shows up. One descriptor has all bits set, which exposes any failure to mask the high-address, size and command fields. Advances alternate between the stepping and the link-following types, and a link word with high bits set checks the 17-bit truncation. Register-mode fetches run beside memory-mode ones to separate the two descriptor sources. Misaligned fetches are driven both directly and at the end of a refill chain. A command presented mid-fetch shows that busy-time commands are dropped. A memory port whose ready follows an irregular pattern tests request holding and read ordering.

// File: rtl/dfu_pkg.sv
`timescale 1ns/1ps
package dfu_pkg;
  localparam int unsigned PTR_W      = 49;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned HI_W       = PTR_W - WORD_W;
  localparam int unsigned SIZE_W     = 30;
  localparam int unsigned DSC_WORDS  = 4;
  localparam int unsigned LINK_WORDS = 2;
  localparam int unsigned DSC_BYTES  = DSC_WORDS * WORD_W / 8;
  localparam int unsigned ALIGN_W    = $clog2(DSC_BYTES);
  localparam int unsigned SIDES      = 2;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_FETCH   = 2'd1,
    OP_ADVANCE = 2'd2,
    OP_REFILL  = 2'd3
  } dfu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_LINK  = 2'd2,
    ST_CHAIN = 2'd3
  } dfu_state_e;

  typedef struct packed {
    logic [PTR_W-1:0]  addr;
    logic [SIZE_W-1:0] size;
    logic [1:0]        cmd;
    logic              intr;
    logic              linked;
    logic              coh;
  } dfu_dsc_t;
endpackage

// File: rtl/dfu_unpack.sv
`timescale 1ns/1ps
module dfu_unpack
  import dfu_pkg::*;
#(
  parameter int unsigned W_W = WORD_W,
  parameter int unsigned N_W = DSC_WORDS
) (
  input  logic [N_W*W_W-1:0] words,
  input  logic               is_dst,
  output dfu_dsc_t           dsc
);
  localparam int unsigned W1 = W_W;
  localparam int unsigned W2 = 2 * W_W;
  localparam int unsigned W3 = 3 * W_W;

  always_comb begin
    dsc.addr   = {words[W1 +: HI_W], words[0 +: W_W]};
    dsc.size   = words[W2 +: SIZE_W];
    dsc.cmd    = is_dst ? 2'b00 : words[W3 + 3 +: 2];
    dsc.intr   = words[W3 + 2];
    dsc.linked = words[W3 + 1];
    dsc.coh    = words[W3];
  end
endmodule

// File: rtl/dfu_ptr_bank.sv
`timescale 1ns/1ps
module dfu_ptr_bank
  import dfu_pkg::*;
#(
  parameter int unsigned N_SIDES = SIDES,
  parameter int unsigned P_W     = PTR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_SIDES-1:0]             ld,
  input  logic [N_SIDES-1:0][P_W-1:0]    ld_val,
  output logic [N_SIDES-1:0][P_W-1:0]    ptr
);
  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    logic [P_W-1:0] ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q <= '0;
      end else if (ld[s]) begin
        ptr_q <= ld_val[s];
      end
    end
    assign ptr[s] = ptr_q;
  end
endmodule

// File: rtl/dfu_rd_engine.sv
`timescale 1ns/1ps
module dfu_rd_engine
  import dfu_pkg::*;
#(
  parameter int unsigned W_W       = WORD_W,
  parameter int unsigned P_W       = PTR_W,
  parameter int unsigned MAX_WORDS = DSC_WORDS,
  localparam int unsigned CNT_W    = $clog2(MAX_WORDS + 1),
  localparam int unsigned BSH      = $clog2(W_W / 8)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     go,
  input  logic [P_W-1:0]           go_base,
  input  logic [CNT_W-1:0]         go_count,
  output logic                     rd_req_valid,
  input  logic                     rd_req_ready,
  output logic [P_W-1:0]           rd_req_addr,
  input  logic                     rd_rsp_valid,
  input  logic [W_W-1:0]           rd_rsp_data,
  output logic [MAX_WORDS*W_W-1:0] words,
  output logic                     done
);
  logic                     active_q, active_d;
  logic                     wait_q, wait_d;
  logic [CNT_W-1:0]         idx_q, idx_d;
  logic [CNT_W-1:0]         cnt_q, cnt_d;
  logic [P_W-1:0]           base_q, base_d;
  logic [MAX_WORDS*W_W-1:0] words_q, words_d;
  logic                     done_q, done_d;

  always_comb begin
    active_d = active_q;
    wait_d   = wait_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    base_d   = base_q;
    words_d  = words_q;
    done_d   = 1'b0;
    if (go && !active_q) begin
      active_d = 1'b1;
      wait_d   = 1'b0;
      idx_d    = '0;
      cnt_d    = go_count;
      base_d   = go_base;
      words_d  = '0;
    end else if (active_q) begin
      if (!wait_q) begin
        if (rd_req_ready) wait_d = 1'b1;
      end else if (rd_rsp_valid) begin
        words_d[idx_q*W_W +: W_W] = rd_rsp_data;
        wait_d = 1'b0;
        idx_d  = idx_q + 1'b1;
        if (idx_q == cnt_q - 1'b1) begin
          active_d = 1'b0;
          done_d   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
      base_q   <= '0;
      words_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      wait_q   <= wait_d;
      idx_q    <= idx_d;
      cnt_q    <= cnt_d;
      base_q   <= base_d;
      words_q  <= words_d;
      done_q   <= done_d;
    end
  end

  assign rd_req_valid = active_q && !wait_q;
  assign rd_req_addr  = base_q + (P_W'(idx_q) << BSH);
  assign words        = words_q;
  assign done         = done_q;
endmodule

// File: rtl/dfu_fetch_unit.sv
`timescale 1ns/1ps
module dfu_fetch_unit
  import dfu_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mem_mode,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic                      cmd_side,
  input  logic [WORD_W-1:0]         src_start_lo,
  input  logic [HI_W-1:0]           src_start_hi,
  input  logic [WORD_W-1:0]         dst_start_lo,
  input  logic [HI_W-1:0]           dst_start_hi,
  input  logic [DSC_WORDS*WORD_W-1:0] src_prog,
  input  logic [DSC_WORDS*WORD_W-1:0] dst_prog,
  output logic                      rd_req_valid,
  input  logic                      rd_req_ready,
  output logic [PTR_W-1:0]          rd_req_addr,
  input  logic                      rd_rsp_valid,
  input  logic [WORD_W-1:0]         rd_rsp_data,
  output logic                      busy,
  output logic [63:0]               cur_src_ptr,
  output logic [63:0]               cur_dst_ptr,
  output logic                      dsc_valid,
  output logic                      dsc_side,
  output logic [PTR_W-1:0]          dsc_addr,
  output logic [SIZE_W-1:0]         dsc_size,
  output logic [1:0]                dsc_cmd,
  output logic                      dsc_intr,
  output logic                      dsc_linked,
  output logic                      dsc_coherent,
  output logic                      err_src,
  output logic                      err_dst,
  output logic                      err_flag
);
  localparam int unsigned CNT_W  = $clog2(DSC_WORDS + 1);
  localparam int unsigned PAD_W  = 64 - PTR_W;
  localparam logic        SRC    = 1'b0;
  localparam logic        DST    = 1'b1;

  // state
  dfu_state_e            state_q, state_d;
  logic                  side_q, side_d;
  logic                  chain_q, chain_d;
  logic [SIDES-1:0]      kind_q, kind_d;
  dfu_dsc_t              dsc_q, dsc_d;
  logic                  dval_q, dval_d;
  logic                  dside_q, dside_d;
  logic                  esrc_q, esrc_d;
  logic                  edst_q, edst_d;
  logic                  eflag_q, eflag_d;

  // pointer bank
  logic [SIDES-1:0]             ptr_ld;
  logic [SIDES-1:0][PTR_W-1:0]  ptr_val;
  logic [SIDES-1:0][PTR_W-1:0]  ptr;

  // read engine
  logic                         eng_go;
  logic [PTR_W-1:0]             eng_base;
  logic [CNT_W-1:0]             eng_cnt;
  logic [DSC_WORDS*WORD_W-1:0]  eng_words;
  logic                         eng_done;

  // unpacked views
  dfu_dsc_t dsc_mem, dsc_psrc, dsc_pdst;
  logic [PTR_W-1:0] link_ptr;

  // action flags
  logic fetch_now, fetch_side;
  logic adv_now, adv_side, adv_chain;

  dfu_ptr_bank #(.N_SIDES(SIDES), .P_W(PTR_W)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ptr_ld),
    .ld_val (ptr_val),
    .ptr    (ptr)
  );

  dfu_rd_engine #(.W_W(WORD_W), .P_W(PTR_W), .MAX_WORDS(DSC_WORDS)) u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (eng_go),
    .go_base      (eng_base),
    .go_count     (eng_cnt),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_rsp_valid (rd_rsp_valid),
    .rd_rsp_data  (rd_rsp_data),
    .words        (eng_words),
    .done         (eng_done)
  );

  dfu_unpack u_unp_mem  (.words(eng_words), .is_dst(side_q), .dsc(dsc_mem));
  dfu_unpack u_unp_psrc (.words(src_prog),  .is_dst(SRC),    .dsc(dsc_psrc));
  dfu_unpack u_unp_pdst (.words(dst_prog),  .is_dst(DST),    .dsc(dsc_pdst));

  assign link_ptr = {eng_words[WORD_W +: HI_W], eng_words[0 +: WORD_W]};

  // command decode and sequencing
  always_comb begin
    state_d  = state_q;
    side_d   = side_q;
    chain_d  = chain_q;
    kind_d   = kind_q;
    dsc_d    = dsc_q;
    dval_d   = 1'b0;
    dside_d  = dside_q;
    esrc_d   = 1'b0;
    edst_d   = 1'b0;
    eflag_d  = eflag_q;
    ptr_ld   = '0;
    ptr_val  = ptr;
    eng_go   = 1'b0;
    eng_base = '0;
    eng_cnt  = '0;
    fetch_now  = 1'b0;
    fetch_side = side_q;
    adv_now    = 1'b0;
    adv_side   = side_q;
    adv_chain  = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          unique case (dfu_op_e'(cmd_op))
            OP_START: begin
              ptr_ld         = '1;
              ptr_val[SRC]   = {src_start_hi, src_start_lo};
              ptr_val[DST]   = {dst_start_hi, dst_start_lo};
              kind_d         = '0;
              eflag_d        = 1'b0;
            end
            OP_FETCH: begin
              fetch_now  = 1'b1;
              fetch_side = cmd_side;
            end
            OP_ADVANCE: begin
              adv_now  = 1'b1;
              adv_side = cmd_side;
            end
            OP_REFILL: begin
              if (mem_mode) begin
                adv_now   = 1'b1;
                adv_side  = DST;
                adv_chain = 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      ST_FETCH: begin
        if (eng_done) begin
          dsc_d          = dsc_mem;
          dval_d         = 1'b1;
          dside_d        = side_q;
          kind_d[side_q] = dsc_mem.linked;
          state_d        = ST_IDLE;
        end
      end
      ST_LINK: begin
        if (eng_done) begin
          ptr_ld[side_q]  = 1'b1;
          ptr_val[side_q] = link_ptr;
          state_d         = chain_q ? ST_CHAIN : ST_IDLE;
        end
      end
      ST_CHAIN: begin
        state_d    = ST_IDLE;
        fetch_now  = 1'b1;
        fetch_side = DST;
      end
      default: state_d = ST_IDLE;
    endcase

    if (fetch_now) begin
      side_d  = fetch_side;
      dside_d = fetch_side;
      if (!mem_mode) begin
        dsc_d              = fetch_side ? dsc_pdst : dsc_psrc;
        dval_d             = 1'b1;
        kind_d[fetch_side] = dsc_d.linked;
      end else if (ptr[fetch_side][ALIGN_W-1:0] != '0) begin
        dsc_d              = '0;
        dval_d             = 1'b1;
        kind_d[fetch_side] = 1'b0;
        eflag_d            = 1'b1;
        esrc_d             = (fetch_side == SRC);
        edst_d             = (fetch_side == DST);
      end else begin
        eng_go   = 1'b1;
        eng_base = ptr[fetch_side];
        eng_cnt  = CNT_W'(DSC_WORDS);
        state_d  = ST_FETCH;
      end
    end

    if (adv_now) begin
      side_d  = adv_side;
      chain_d = adv_chain;
      if (!kind_q[adv_side]) begin
        ptr_ld[adv_side]  = 1'b1;
        ptr_val[adv_side] = ptr[adv_side] + PTR_W'(DSC_BYTES);
        state_d           = adv_chain ? ST_CHAIN : ST_IDLE;
      end else begin
        eng_go   = 1'b1;
        eng_base = ptr[adv_side] + PTR_W'(DSC_BYTES);
        eng_cnt  = CNT_W'(LINK_WORDS);
        state_d  = ST_LINK;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      side_q  <= 1'b0;
      chain_q <= 1'b0;
      kind_q  <= '0;
      dsc_q   <= '0;
      dval_q  <= 1'b0;
      dside_q <= 1'b0;
      esrc_q  <= 1'b0;
      edst_q  <= 1'b0;
      eflag_q <= 1'b0;
    end else begin
      state_q <= state_d;
      side_q  <= side_d;
      chain_q <= chain_d;
      kind_q  <= kind_d;
      dsc_q   <= dsc_d;
      dval_q  <= dval_d;
      dside_q <= dside_d;
      esrc_q  <= esrc_d;
      edst_q  <= edst_d;
      eflag_q <= eflag_d;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign cur_src_ptr  = {{PAD_W{1'b0}}, ptr[SRC]};
  assign cur_dst_ptr  = {{PAD_W{1'b0}}, ptr[DST]};
  assign dsc_valid    = dval_q;
  assign dsc_side     = dside_q;
  assign dsc_addr     = dsc_q.addr;
  assign dsc_size     = dsc_q.size;
  assign dsc_cmd      = dsc_q.cmd;
  assign dsc_intr     = dsc_q.intr;
  assign dsc_linked   = dsc_q.linked;
  assign dsc_coherent = dsc_q.coh;
  assign err_src      = esrc_q;
  assign err_dst      = edst_q;
  assign err_flag     = eflag_q;
endmodule

// File: rtl/dfu_fetch_chk.sv
`timescale 1ns/1ps
module dfu_fetch_chk
  import dfu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [PTR_W-1:0]  rd_req_addr,
  input logic              busy,
  input logic [63:0]       cur_src_ptr,
  input logic [63:0]       cur_dst_ptr,
  input logic              dsc_valid,
  input logic              dsc_side,
  input logic [PTR_W-1:0]  dsc_addr,
  input logic [SIZE_W-1:0] dsc_size,
  input logic [1:0]        dsc_cmd,
  input logic              dsc_linked,
  input logic              err_src,
  input logic              err_dst,
  input logic              err_flag
);
  // R4: destination descriptors carry no command
  a_r4_dst_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (dsc_valid && dsc_side) |-> (dsc_cmd == 2'b00));

  // R7: an alignment error delivers an all-zero descriptor
  a_r7_err_zero_dsc: assert property (@(posedge clk) disable iff (!rst_n)
    (err_src || err_dst) |-> (dsc_valid && dsc_addr == '0 && dsc_size == '0 && !dsc_linked));

  // R7: sticky error survives everything but a start
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !(cmd_valid && !busy && cmd_op == 2'd0)) |=> err_flag);

  // R11: request held with stable address until accepted
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R3: reads only happen while a command is in progress
  a_r3_no_req_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid);

  // R3: descriptor delivery coincides with the end of the command
  a_r3_valid_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    dsc_valid |-> !busy);

  // R5: pointers hold while idle with no command
  a_r5_ptr_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> ($stable(cur_src_ptr) && $stable(cur_dst_ptr)));
endmodule

bind dfu_fetch_unit dfu_fetch_chk u_chk (.*);

// File: tb/dfu_fetch_unit_tb.sv
`timescale 1ns/1ps
module dfu_fetch_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic mem_mode, cmd_valid, cmd_side;
  logic [1:0] cmd_op;
  logic [31:0] src_start_lo, dst_start_lo;
  logic [16:0] src_start_hi, dst_start_hi;
  logic [127:0] src_prog, dst_prog;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [48:0] rd_req_addr;
  logic [31:0] rd_rsp_data;
  logic busy, dsc_valid, dsc_side, dsc_intr, dsc_linked, dsc_coherent;
  logic [63:0] cur_src_ptr, cur_dst_ptr;
  logic [48:0] dsc_addr;
  logic [29:0] dsc_size;
  logic [1:0] dsc_cmd;
  logic err_src, err_dst, err_flag;

  always #2.5 clk = ~clk;

  dfu_fetch_unit u_dut (.*);

  // memory model
  logic [31:0] mem [0:63];
  int unsigned rdy_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_req_ready <= 1'b0; rd_rsp_valid <= 1'b0; rd_rsp_data <= '0; rdy_cnt <= 0;
    end else begin
      rdy_cnt      <= rdy_cnt + 1;
      rd_req_ready <= ((rdy_cnt % 3) != 2);
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= mem[rd_req_addr[7:2]];
    end
  end

  int checks = 0, bad = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference model
  logic [48:0] m_ptr [2];
  bit m_kind [2];
  bit m_err;
  logic [48:0] exp_addr [$];
  logic [86:0] exp_dsc [$];

  function automatic logic [86:0] mk(input bit side, input logic [31:0] w0, w1, w2, w3,
                                     input bit es, input bit ed);
    logic [1:0] c;
    c = side ? 2'b00 : w3[4:3];
    return {side, w1[16:0], w0, w2[29:0], c, w3[2], w3[1], w3[0], es, ed};
  endfunction

  function automatic logic [31:0] rdw(input logic [48:0] a);
    return mem[a[7:2]];
  endfunction

  task automatic mdl_fetch(input bit s);
    if (!mem_mode) begin
      logic [127:0] p;
      p = s ? dst_prog : src_prog;
      exp_dsc.push_back(mk(s, p[31:0], p[63:32], p[95:64], p[127:96], 0, 0));
      m_kind[s] = p[97];
    end else if (m_ptr[s][3:0] != 0) begin
      exp_dsc.push_back({s, 84'd0, ~s, s});
      m_kind[s] = 0; m_err = 1;
    end else begin
      for (int k = 0; k < 4; k++) exp_addr.push_back(m_ptr[s] + 49'(4*k));
      exp_dsc.push_back(mk(s, rdw(m_ptr[s]), rdw(m_ptr[s]+4), rdw(m_ptr[s]+8),
                           rdw(m_ptr[s]+12), 0, 0));
      m_kind[s] = rdw(m_ptr[s]+12) & 32'h2 ? 1'b1 : 1'b0;
    end
  endtask

  task automatic mdl_adv(input bit s);
    if (!m_kind[s]) m_ptr[s] = m_ptr[s] + 16;
    else begin
      logic [31:0] lo, hi;
      exp_addr.push_back(m_ptr[s] + 16);
      exp_addr.push_back(m_ptr[s] + 20);
      lo = rdw(m_ptr[s] + 16); hi = rdw(m_ptr[s] + 20);
      m_ptr[s] = {hi[16:0], lo};
    end
  endtask

  task automatic send(input logic [1:0] op, input bit s);
    case (op)
      2'd0: begin
        m_ptr[0] = {src_start_hi, src_start_lo}; m_ptr[1] = {dst_start_hi, dst_start_lo};
        m_kind[0] = 0; m_kind[1] = 0; m_err = 0;
      end
      2'd1: mdl_fetch(s);
      2'd2: mdl_adv(s);
      default: if (mem_mode) begin mdl_adv(1); mdl_fetch(1); end
    endcase
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_side = s;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk_state(input string req);
    check(cur_src_ptr == {15'd0, m_ptr[0]}, req, "src ptr", cur_src_ptr, {15'd0, m_ptr[0]});
    check(cur_dst_ptr == {15'd0, m_ptr[1]}, req, "dst ptr", cur_dst_ptr, {15'd0, m_ptr[1]});
    check(err_flag == m_err, req, "err_flag", err_flag, m_err);
    check(exp_addr.size() == 0 && exp_dsc.size() == 0, req, "pending expectations",
          exp_addr.size() + exp_dsc.size(), 0);
  endtask

  // per-clock comparison
  logic [48:0] held_addr;
  bit held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check(rd_req_valid && rd_req_addr == held_addr, "R11", "request held",
              {rd_req_valid, rd_req_addr}, {1'b1, held_addr});
      end
      held = rd_req_valid && !rd_req_ready;
      held_addr = rd_req_addr;
      if (rd_req_valid && rd_req_ready) begin
        if (exp_addr.size() == 0) check(0, "R3", "unexpected read", rd_req_addr, 0);
        else begin
          logic [48:0] e;
          e = exp_addr.pop_front();
          check(rd_req_addr == e, "R3", "read address", rd_req_addr, e);
        end
      end
      if (dsc_valid) begin
        logic [86:0] a;
        a = {dsc_side, dsc_addr, dsc_size, dsc_cmd, dsc_intr, dsc_linked, dsc_coherent,
             err_src, err_dst};
        if (exp_dsc.size() == 0) check(0, "R3", "unexpected descriptor", a, 0);
        else begin
          logic [86:0] e;
          e = exp_dsc.pop_front();
          check(a == e, "R3", "descriptor fields", a, e);
        end
      end else begin
        check(!err_src && !err_dst, "R7", "error pulse without descriptor", {err_src, err_dst}, 0);
      end
    end
  end

  int unsigned cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      bad++;
      $display("FAIL R3 watchdog expired act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    held = 0;
    rst_n = 0; mem_mode = 1; cmd_valid = 0; cmd_op = 0; cmd_side = 0;
    src_start_lo = 32'h40; src_start_hi = 0; dst_start_lo = 32'h80; dst_start_hi = 0;
    src_prog = '0; dst_prog = '0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[16] = 32'h1234_5678; mem[17] = 32'h0001_ABCD; mem[18] = 32'hC000_0100; mem[19] = 32'h0000_001D;
    mem[20] = 32'h0000_2000; mem[21] = 32'h0;         mem[22] = 32'h0000_0040; mem[23] = 32'h0000_000A;
    mem[24] = 32'h0000_00A0; mem[25] = 32'hFFFF_0000;
    mem[40] = 32'hDEAD_BEE0; mem[41] = 32'hFFFF_FFFF; mem[42] = 32'hFFFF_FFFF; mem[43] = 32'hFFFF_FFFF;
    mem[32] = 32'h0000_3000; mem[33] = 32'h0000_0002; mem[34] = 32'h0000_0080; mem[35] = 32'h0000_001F;
    mem[36] = 32'h0000_00C0; mem[37] = 32'h0;
    mem[48] = 32'h0000_4000; mem[49] = 32'h0;         mem[50] = 32'h0000_0020; mem[51] = 32'h0000_0006;
    mem[52] = 32'h0000_0013; mem[53] = 32'h0;
    m_ptr[0] = 0; m_ptr[1] = 0; m_kind[0] = 0; m_kind[1] = 0; m_err = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !dsc_valid && !err_flag && !rd_req_valid && !err_src && !err_dst,
          "R1", "reset outputs", {busy, dsc_valid, err_flag, rd_req_valid}, 0);
    check(cur_src_ptr == 0 && cur_dst_ptr == 0, "R1", "reset pointers", cur_src_ptr, 0);
    rst_n = 1;
    @(negedge clk);

    send(0, 0); wait_idle(); chk_state("R2");
    send(1, 0); wait_idle(); chk_state("R3");           // linear src descriptor
    send(2, 0); wait_idle(); chk_state("R5");           // +16
    send(1, 0); wait_idle(); chk_state("R3");           // linked src descriptor
    send(2, 0); wait_idle(); chk_state("R6");           // follow link, high bits masked
    check(cur_src_ptr[63:49] == 0 && cur_src_ptr[48], "R2", "pointer high bits", cur_src_ptr, 64'h1_0000_0000_00A0);
    send(1, 0); wait_idle(); chk_state("R3");           // all-ones descriptor
    send(1, 1); wait_idle(); chk_state("R4");           // dst, cmd forced 0
    send(3, 1); wait_idle(); chk_state("R9");           // link refill then fetch
    send(3, 1); wait_idle(); chk_state("R7");           // refill lands misaligned
    check(err_flag == 1, "R7", "sticky err_flag", err_flag, 1);
    send(0, 0); wait_idle(); chk_state("R2");           // clears err_flag

    // R10: start presented while busy is ignored
    mdl_fetch(0);
    @(negedge clk); cmd_valid = 1; cmd_op = 1; cmd_side = 0;
    @(negedge clk); cmd_op = 0; src_start_lo = 32'h100; dst_start_lo = 32'h200;
    check(busy == 1, "R10", "busy during fetch", busy, 1);
    @(negedge clk); cmd_valid = 0;
    wait_idle(); chk_state("R10");

    // R8: register mode
    mem_mode = 0;
    src_prog = {32'h0000_0012, 32'h7FFF_FFFF, 32'h0002_0001, 32'hCAFE_F00D};
    dst_prog = {32'h0000_001B, 32'h0000_0010, 32'h0000_0003, 32'h0BAD_0000};
    send(1, 0);
    check(dsc_valid == 1, "R8", "valid next cycle", dsc_valid, 1);
    wait_idle(); chk_state("R8");
    send(1, 1);
    check(dsc_valid == 1 && dsc_cmd == 0, "R8", "dst prog valid", {dsc_valid, dsc_cmd}, 3'b100);
    wait_idle(); chk_state("R8");
    send(3, 1);
    check(busy == 0, "R9", "refill ignored in register mode", busy, 0);
    wait_idle(); chk_state("R9");

    // R7: direct misaligned fetch, then step from cleared type
    mem_mode = 1; src_start_lo = 32'h44; dst_start_lo = 32'h80;
    send(0, 0); wait_idle();
    send(1, 0); wait_idle(); chk_state("R7");
    send(2, 0); wait_idle(); chk_state("R5");

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule